// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

This block collects up to 32 interrupt requests and turns them into two processor-facing request lines, one critical and one non-critical. Each source is set up on its own as edge or level sensitive, and for either kind its active sense (rising/high or falling/low) is selectable. Detected events are latched into a status register. Software clears a status bit by writing a one to it. An enable register decides which latched sources may reach the outputs, and a per-source routing register sends each enabled source to either the critical or the non-critical line.

Software reaches six registers through a simple request port with a one-cycle read latency. Source inputs are asynchronous and pass through a two-flop synchronizer before detection. To build a larger tree, wire one controller's output line into an input of another controller and set that input to level sensitive.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset, the enable, routing and trigger registers read 0, polarity reads all ones, status reads 0 while every input is low, and both output lines are low.
- R2: Source n uses bit 31-n of `irq_in` and of every register, so source 0 is the most significant bit.
- R3: A level-sensitive source (trigger bit 0) keeps its status bit set for as long as its input is at the active level. This holds whether or not the source is enabled, and writing a one to clear the bit has no lasting effect while the input stays active.
- R4: With polarity bit 0, a level source is active while its input is low. With polarity bit 1, it is active while its input is high.
- R5: An edge-sensitive source (trigger bit 1) sets its status bit on one edge of its synchronized input. The bit then stays set after the input returns to idle, until a one is written to that bit. Writing a zero leaves the bit unchanged.
- R6: An edge source with polarity bit 0 responds to a falling edge, and a rising edge on it has no effect.
- R7: Masked status (offset 5) reads as status AND enable. Status bits latch even when the source is disabled. Writes to offset 5 are ignored.
- R8: The critical line is the registered OR of masked status AND routing. The non-critical line is the registered OR of masked status AND NOT routing. Each line changes one cycle after the register change that causes it.
- R9: Register offsets are 0 status, 1 enable, 2 routing, 3 polarity, 4 trigger, 5 masked status. A read returns its data with `rd_valid` high one cycle after the request. Offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous source inputs, source n on bit 31-n |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| irq_crit | output | 1 | Critical request line |
| irq_noncrit | output | 1 | Non-critical request line |

## Verification
A corrupted status bit shows up when software reads offset 0 or 5 in the cycle after the request. If that source is enabled, it also shows up as a wrong output line one cycle after the fault. A wrong edge-history flop either loses an event or creates a spurious one, and a status read taken a few cycles after the input toggles exposes it. Per-source sweeps walk every bit position in edge and level modes, so a fault in any single bit's detection or clearing path surfaces within about ten cycles of that source's turn.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC = 32;
    localparam int AW   = 3;

    typedef enum logic [AW-1:0] {
        OFF_STAT  = 3'd0,
        OFF_ENA   = 3'd1,
        OFF_CRIT  = 3'd2,
        OFF_POL   = 3'd3,
        OFF_TRIG  = 3'd4,
        OFF_MSTAT = 3'd5
    } reg_off_e;

    typedef struct packed {
        logic [NSRC-1:0] ena;
        logic [NSRC-1:0] crit;
        logic [NSRC-1:0] pol;
        logic [NSRC-1:0] trig;
    } cfg_t;

    // Bit mask of source n (MSB-first numbering)
    function automatic logic [NSRC-1:0] src_mask(input int unsigned n);
        return {{(NSRC-1){1'b0}}, 1'b1} << (NSRC - 1 - n);
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;

endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] trig,
    input  logic [W-1:0] pol,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic rise, fall, active;
        assign rise   = lvl[i] & ~prev_q[i];
        assign fall   = ~lvl[i] & prev_q[i];
        assign active = pol[i] ? lvl[i] : ~lvl[i];
        assign evt[i] = trig[i] ? (pol[i] ? rise : fall) : active;
    end

    // An edge source with stable configuration never fires two cycles in a row
    AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ((evt & trig & $past(evt) & $past(trig) & ~(pol ^ $past(pol))) == '0)); // R5

endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat
);
    logic [W-1:0] stat_q;

    // A new event takes precedence over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr) | evt;
    end

    assign stat = stat_q;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(evt)) == $past(evt))); // R3

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(clr & ~evt)) == '0)); // R5

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(stat_q & ~clr)) == $past(stat_q & ~clr))); // R5

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
    import irqc_pkg::*;
#(
    parameter logic [NSRC-1:0] POL_INIT = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_in,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [NSRC-1:0] req_wdata,
    output logic [NSRC-1:0] rd_data,
    output logic            rd_valid,
    output logic            irq_crit,
    output logic            irq_noncrit
);
    cfg_t            cfg_q;
    logic [NSRC-1:0] lvl_sync;
    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] stat;
    logic [NSRC-1:0] masked;
    logic [NSRC-1:0] rd_mux;
    logic            wr_en;
    logic            rd_en;

    assign wr_en = req_valid & req_write;
    assign rd_en = req_valid & ~req_write;

    irqc_sync #(.W(NSRC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (irq_in),
        .dout (lvl_sync)
    );

    irqc_detect #(.W(NSRC)) u_detect (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl_sync),
        .trig (cfg_q.trig),
        .pol  (cfg_q.pol),
        .evt  (evt)
    );

    assign clr = (wr_en && req_addr == OFF_STAT) ? req_wdata : '0;

    irqc_status #(.W(NSRC)) u_status (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .clr  (clr),
        .stat (stat)
    );

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.ena  <= '0;
            cfg_q.crit <= '0;
            cfg_q.pol  <= POL_INIT;
            cfg_q.trig <= '0;
        end else if (wr_en) begin
            case (req_addr)
                OFF_ENA:  cfg_q.ena  <= req_wdata;
                OFF_CRIT: cfg_q.crit <= req_wdata;
                OFF_POL:  cfg_q.pol  <= req_wdata;
                OFF_TRIG: cfg_q.trig <= req_wdata;
                default:  ;
            endcase
        end
    end

    assign masked = stat & cfg_q.ena;

    always_comb begin
        case (req_addr)
            OFF_STAT:  rd_mux = stat;
            OFF_ENA:   rd_mux = cfg_q.ena;
            OFF_CRIT:  rd_mux = cfg_q.crit;
            OFF_POL:   rd_mux = cfg_q.pol;
            OFF_TRIG:  rd_mux = cfg_q.trig;
            OFF_MSTAT: rd_mux = masked;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            irq_crit    <= 1'b0;
            irq_noncrit <= 1'b0;
        end else begin
            rd_valid    <= rd_en;
            if (rd_en) rd_data <= rd_mux;
            irq_crit    <= |(masked & cfg_q.crit);
            irq_noncrit <= |(masked & ~cfg_q.crit);
        end
    end

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.ena == '0) |=> (!irq_crit && !irq_noncrit)); // R7

    AST_LINES_EXCLUSIVE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (stat == '0) |=> (!irq_crit && !irq_noncrit)); // R8

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R9

    AST_MSTAT_READONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req_addr == OFF_MSTAT) |=> $stable(cfg_q)); // R7

endmodule

// File: tb/test_irqc_ctrl.sv
module test_irqc_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        irq_crit;
    logic        irq_noncrit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] rv;
    logic        rvalid;

    always #5 clk = ~clk;

    irqc_ctrl i_irqc_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .irq_crit(irq_crit), .irq_noncrit(irq_noncrit)
    );

    function automatic logic [31:0] bitof(input int n);
        return 32'h1 << (31 - n);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rv = rd_data;
        rvalid = rd_valid;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(3'd1); chk(rv, 32'h0, "R1 enable");
        rd(3'd2); chk(rv, 32'h0, "R1 routing");
        rd(3'd4); chk(rv, 32'h0, "R1 trigger");
        rd(3'd3); chk(rv, 32'hffff_ffff, "R1 polarity");
        settle();
        rd(3'd0); chk(rv, 32'h0, "R1 status");
        chk({30'd0, irq_crit, irq_noncrit}, 32'h0, "R1 outputs");

        // R9 read timing, readback, unused offsets
        wr(3'd2, 32'ha5a5_0f0f);
        rd(3'd2); chk(rv, 32'ha5a5_0f0f, "R9 readback");
        chk({31'd0, rvalid}, 32'h1, "R9 rd_valid high");
        @(negedge clk); chk({31'd0, rd_valid}, 32'h0, "R9 rd_valid pulse");
        rd(3'd6); chk(rv, 32'h0, "R9 offset 6");
        rd(3'd7); chk(rv, 32'h0, "R9 offset 7");
        wr(3'd2, 32'h0);

        // R5 R2 rising-edge sweep over every source
        for (int n = 0; n < 32; n++) begin
            logic [31:0] m;
            m = bitof(n);
            wr(3'd4, m);
            wr(3'd0, 32'hffff_ffff);
            @(negedge clk) irq_in = m;
            @(negedge clk) irq_in = '0;
            settle();
            rd(3'd0); chk(rv, m, $sformatf("R2 R5 edge latch src %0d", n));
            wr(3'd0, 32'h0);
            rd(3'd0); chk(rv, m, $sformatf("R5 zero write src %0d", n));
            wr(3'd0, m);
            rd(3'd0); chk(rv, 32'h0, $sformatf("R5 clear src %0d", n));
        end
        wr(3'd4, 32'h0);

        // R4 R3 level-low sweep over every source
        for (int n = 0; n < 32; n++) begin
            logic [31:0] m;
            m = bitof(n);
            irq_in = m;
            settle();
            wr(3'd3, ~m);
            wr(3'd0, 32'hffff_ffff);
            rd(3'd0); chk(rv, 32'h0, $sformatf("R4 inactive high src %0d", n));
            @(negedge clk) irq_in = '0;
            settle();
            rd(3'd0); chk(rv, m, $sformatf("R4 active low src %0d", n));
            wr(3'd0, m);
            rd(3'd0); chk(rv, m, $sformatf("R3 sticky while active src %0d", n));
            @(negedge clk) irq_in = m;
            settle();
            wr(3'd0, m);
            rd(3'd0); chk(rv, 32'h0, $sformatf("R3 clear after idle src %0d", n));
            wr(3'd3, 32'hffff_ffff);
            @(negedge clk) irq_in = '0;
            settle();
            wr(3'd0, 32'hffff_ffff);
        end

        // R3 level-high while disabled, source 9
        @(negedge clk) irq_in = bitof(9);
        settle();
        rd(3'd0); chk(rv, bitof(9), "R3 level high latches while disabled");
        wr(3'd0, bitof(9));
        rd(3'd0); chk(rv, bitof(9), "R3 clear ignored while high");
        @(negedge clk) irq_in = '0;
        settle();
        wr(3'd0, bitof(9));
        rd(3'd0); chk(rv, 32'h0, "R3 clear after release");

        // R6 falling edge, source 5
        @(negedge clk) irq_in = bitof(5);
        settle();
        wr(3'd4, bitof(5));
        wr(3'd3, ~bitof(5));
        wr(3'd0, 32'hffff_ffff);
        rd(3'd0); chk(rv, 32'h0, "R6 no event while high");
        @(negedge clk) irq_in = '0;
        settle();
        rd(3'd0); chk(rv, bitof(5), "R6 falling edge latches");
        wr(3'd0, bitof(5));
        @(negedge clk) irq_in = bitof(5);
        settle();
        rd(3'd0); chk(rv, 32'h0, "R6 rising edge ignored");
        @(negedge clk) irq_in = '0;
        settle();
        wr(3'd0, 32'hffff_ffff);
        wr(3'd3, 32'hffff_ffff);

        // R7 R8 masking and routing, source 3 on a rising edge
        wr(3'd4, bitof(3));
        @(negedge clk) irq_in = bitof(3);
        @(negedge clk) irq_in = '0;
        settle();
        rd(3'd5); chk(rv, 32'h0, "R7 masked zero when disabled");
        chk({30'd0, irq_crit, irq_noncrit}, 32'h0, "R7 lines quiet when disabled");
        rd(3'd0); chk(rv, bitof(3), "R7 latched while disabled");
        wr(3'd1, bitof(3) | bitof(20));
        chk({30'd0, irq_crit, irq_noncrit}, 32'h0, "R8 registered delay");
        @(negedge clk);
        chk({30'd0, irq_crit, irq_noncrit}, 32'h1, "R8 non-critical line");
        rd(3'd5); chk(rv, bitof(3), "R7 masked status");
        wr(3'd2, bitof(3));
        @(negedge clk);
        chk({30'd0, irq_crit, irq_noncrit}, 32'h2, "R8 critical line");
        wr(3'd5, 32'hffff_ffff);
        rd(3'd0); chk(rv, bitof(3), "R7 write to masked ignored");
        rd(3'd1); chk(rv, bitof(3) | bitof(20), "R7 enable unchanged");
        wr(3'd0, bitof(3));
        @(negedge clk);
        chk({30'd0, irq_crit, irq_noncrit}, 32'h0, "R8 lines drop after clear");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule